// File: doc/BRIEF.md
# Memory Bus Address Decoder

This block sits between an 8-bit CPU core and its memories. It takes a 16-bit address and splits the space into regions. The low half goes to an external ROM port. A 256-byte boot image can hide the bottom of that ROM. Three on-chip RAMs sit behind fixed windows: video, work and high RAM. A second window mirrors work RAM. A single control address turns off the boot image. Any address that no region claims gives an error pulse.

The CPU gives a read or write strobe for one cycle. It may also ask for a 16-bit word. A word is done as two byte cycles: the low byte at the given address, then the high byte at the address plus one. A done pulse marks the end of every access. For reads, the result sits on the read-data port while done is high.

Top module: `membus_decode`

## Requirements
- R1: After reset, `bus_done` and `bus_err` are 0 and the boot overlay is on: a byte read of address 0xFF50 returns 0x0001.
- R2: A byte read at 0x0000–0x7FFF with the overlay off, or at 0x0100–0x7FFF with it on, drives `rom_addr` with address bits [14:0]. It raises `rom_rd` during the strobe cycle and returns the `rom_data` byte in `bus_rdata[7:0]`, with bits [15:8] at 0.
- R3: While the overlay is on, a byte read below 0x0100 returns boot byte (7·i + 3) mod 256 for offset i. `rom_rd` stays low.
- R4: A write to 0xFF50 with data bit 0 at 1 turns the overlay off. A write with bit 0 at 0 changes nothing. Once off, the overlay stays off until reset. A read of 0xFF50 returns the overlay state in bit 0.
- R5: 0x8000–0x9FFF maps to an 8 KiB video RAM at offset address − 0x8000. A written byte reads back.
- R6: 0xC000–0xDFFF maps to an 8 KiB work RAM at offset address − 0xC000. 0xE000–0xFDFF reaches the same RAM at address − 0xE000.
- R7: 0xFF80–0xFFFE maps to a 127-byte high RAM at offset address − 0xFF80.
- R8: Any access to 0xA000–0xBFFF, to 0xFE00–0xFF7F other than 0xFF50, or to 0xFFFF sets `bus_err` together with `bus_done`. Such a read returns 0xFF in that byte.
- R9: A write to the ROM or boot range raises no error and keeps `rom_rd` low. The boot image does not change.
- R10: A word access moves the low byte at A and the high byte at A+1. `bus_done` is low one cycle after the strobe and high the cycle after that. A word read returns {byte at A+1, byte at A}.
- R11: A word access sets `bus_err` if either of its two bytes falls in an unsupported address.
- R12: A byte access raises `bus_done` in the cycle right after the strobe, with its read data valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 16 | Write data; low byte for byte writes |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle; wins over `bus_rd` |
| bus_word | input | 1 | Strobe is a 16-bit word access |
| bus_rdata | output | 16 | Read data, valid while `bus_done` is high |
| bus_done | output | 1 | Access complete pulse |
| bus_err | output | 1 | Unsupported address pulse, with `bus_done` |
| rom_addr | output | 15 | External ROM byte address |
| rom_rd | output | 1 | External ROM read enable, in the strobe cycle |
| rom_data | input | 8 | External ROM byte, sampled at the clock edge ending the strobe cycle |

## Verification
A byte result comes one edge after the strobe: `bus_done`, `bus_err` and `bus_rdata` must be valid just after that edge. A word result comes two edges after the strobe, and `bus_done` must stay low after the first edge. `rom_rd` is combinational and is checked inside the strobe cycle itself. The bench drives and samples on falling edges. It waits exactly one or two rising edges for each access, so every result is read in the cycle it is due.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic [2:0] {
    RG_NONE, RG_ROM, RG_BOOT, RG_VRAM, RG_WRAM, RG_HRAM, RG_CTRL
  } region_t;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  // Region boundaries
  localparam logic [15:0] ROM_TOP   = 16'h8000;
  localparam logic [15:0] VRAM_TOP  = 16'hA000;
  localparam logic [15:0] WRAM_BASE = 16'hC000;
  localparam logic [15:0] ECHO_TOP  = 16'hFE00;
  localparam logic [15:0] HRAM_BASE = 16'hFF80;
  localparam logic [15:0] HRAM_LAST = 16'hFFFE;

  // Boot image content: (7*i + 3) mod 256
  function automatic logic [7:0] boot_byte(input logic [7:0] idx);
    logic [7:0] t;
    t = idx * 8'd7;
    return t + 8'd3;
  endfunction
endpackage

// File: rtl/membus_region_decode.sv
module membus_region_decode
  import membus_pkg::*;
#(
  parameter int          OFF_W      = 13,
  parameter logic [15:0] BOOT_LIMIT = 16'h0100,
  parameter logic [15:0] CTRL_ADDR  = 16'hFF50
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              boot_on,
  output region_t           region,
  output logic [OFF_W-1:0]  offset
);
  // Video and work windows are 8 KiB aligned, so the echo window
  // (base 0xE000) and work RAM share the same low address bits.
  always_comb begin
    offset = addr[OFF_W-1:0];
    if (addr < ROM_TOP)
      region = (boot_on && addr < BOOT_LIMIT) ? RG_BOOT : RG_ROM;
    else if (addr < VRAM_TOP)
      region = RG_VRAM;
    else if (addr >= WRAM_BASE && addr < ECHO_TOP)
      region = RG_WRAM;
    else if (addr >= HRAM_BASE && addr <= HRAM_LAST)
      region = RG_HRAM;
    else if (addr == CTRL_ADDR)
      region = RG_CTRL;
    else
      region = RG_NONE;
  end
endmodule

// File: rtl/membus_byte_ram.sv
module membus_byte_ram #(
  parameter int DEPTH  = 8192,
  parameter int BYTE_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  // Single port, synchronous read; output holds when not reading
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/membus_decode.sv
module membus_decode
  import membus_pkg::*;
#(
  parameter int          VRAM_DEPTH = 8192,
  parameter int          WRAM_DEPTH = 8192,
  parameter int          HRAM_DEPTH = 127,
  parameter int          ROM_AW     = 15,
  parameter logic [15:0] CTRL_ADDR  = 16'hFF50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_word,
  output logic [15:0]       bus_rdata,
  output logic              bus_done,
  output logic              bus_err,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_rd,
  input  logic [7:0]        rom_data
);
  localparam int NRAM  = 3;
  localparam int OFF_W = $clog2(VRAM_DEPTH > WRAM_DEPTH ? VRAM_DEPTH : WRAM_DEPTH);
  localparam int RAM_DEPTH [NRAM] = '{VRAM_DEPTH, WRAM_DEPTH, HRAM_DEPTH};
  localparam region_t RAM_REGION [NRAM] = '{RG_VRAM, RG_WRAM, RG_HRAM};

  // Access sequencing state
  logic        second_q;   // high byte of a word pending
  logic [15:0] addr2_q;
  logic        wr2_q;
  logic [7:0]  whi_q;
  logic        err_lo_q;
  logic        word_q;
  logic [7:0]  low_hold_q;
  logic        boot_on_q;
  region_t     sel_q;
  logic [7:0]  rom_q, boot_q;
  logic        ctrl_q;

  logic        strobe, act, acc_wr;
  logic [15:0] acc_addr;
  logic [7:0]  acc_data;
  region_t     region;
  logic [OFF_W-1:0] offset;
  logic [7:0]  ram_q [NRAM];
  logic [7:0]  byte_out;

  assign strobe   = bus_rd | bus_wr;
  assign act      = second_q | strobe;
  assign acc_addr = second_q ? addr2_q : bus_addr;
  assign acc_wr   = second_q ? wr2_q   : bus_wr;
  assign acc_data = second_q ? whi_q   : bus_wdata[7:0];

  membus_region_decode #(
    .OFF_W     (OFF_W),
    .BOOT_LIMIT(16'h0100),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_dec (
    .addr   (acc_addr),
    .boot_on(boot_on_q),
    .region (region),
    .offset (offset)
  );

  generate
    for (genvar g = 0; g < NRAM; g++) begin : g_ram
      localparam int AWG = $clog2(RAM_DEPTH[g]);
      membus_byte_ram #(.DEPTH(RAM_DEPTH[g]), .BYTE_W(BYTE_W)) u_ram (
        .clk  (clk),
        .en   (act && region == RAM_REGION[g]),
        .we   (acc_wr),
        .addr (offset[AWG-1:0]),
        .wdata(acc_data),
        .rdata(ram_q[g])
      );
    end
  endgenerate

  assign rom_addr = acc_addr[ROM_AW-1:0];
  assign rom_rd   = act && !acc_wr && region == RG_ROM;

  // Read sources for ROM, boot image and control register
  always_ff @(posedge clk) begin
    if (rom_rd) rom_q <= rom_data;
    if (act && !acc_wr && region == RG_BOOT) boot_q <= boot_byte(offset[7:0]);
    if (act && !acc_wr && region == RG_CTRL) ctrl_q <= boot_on_q;
  end

  always_comb begin
    case (sel_q)
      RG_ROM:  byte_out = rom_q;
      RG_BOOT: byte_out = boot_q;
      RG_VRAM: byte_out = ram_q[0];
      RG_WRAM: byte_out = ram_q[1];
      RG_HRAM: byte_out = ram_q[2];
      RG_CTRL: byte_out = {7'd0, ctrl_q};
      default: byte_out = 8'hFF;
    endcase
  end

  assign bus_rdata = word_q ? {byte_out, low_hold_q} : {8'h00, byte_out};

  always_ff @(posedge clk) begin
    if (rst) begin
      second_q   <= 1'b0;
      addr2_q    <= '0;
      wr2_q      <= 1'b0;
      whi_q      <= '0;
      err_lo_q   <= 1'b0;
      word_q     <= 1'b0;
      low_hold_q <= '0;
      boot_on_q  <= 1'b1;
      sel_q      <= RG_NONE;
      bus_done   <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_done <= 1'b0;
      bus_err  <= 1'b0;
      if (act) sel_q <= region;
      if (act && acc_wr && region == RG_CTRL && acc_data[0])
        boot_on_q <= 1'b0;
      if (second_q) begin
        second_q   <= 1'b0;
        bus_done   <= 1'b1;
        bus_err    <= err_lo_q | (region == RG_NONE);
        low_hold_q <= byte_out;
      end else if (strobe) begin
        word_q <= bus_word;
        if (bus_word) begin
          second_q <= 1'b1;
          addr2_q  <= bus_addr + 16'd1;
          wr2_q    <= bus_wr;
          whi_q    <= bus_wdata[15:8];
          err_lo_q <= (region == RG_NONE);
        end else begin
          bus_done <= 1'b1;
          bus_err  <= (region == RG_NONE);
        end
      end
    end
  end

  AST_BYTE_DONE_NEXT: assert property (@(posedge clk) disable iff (rst)
    (!second_q && strobe && !bus_word) |=> bus_done);                  // R12
  AST_WORD_DONE_LATE: assert property (@(posedge clk) disable iff (rst)
    (!second_q && strobe && bus_word) |=> (!bus_done ##1 bus_done));   // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_done);                                             // R8
  AST_BOOT_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !boot_on_q |=> !boot_on_q);                                        // R4
  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !second_q) |-> !rom_rd);                                // R9
endmodule

// File: tb/sim_membus_decode.sv
module sim_membus_decode;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_rd, bus_wr, bus_word, bus_done, bus_err;
  logic [14:0] rom_addr;
  logic        rom_rd;
  logic [7:0]  rom_data;

  always #4 clk = ~clk;   // 125 MHz

  function automatic logic [7:0] rom_model(input logic [14:0] a);
    return a[7:0] ^ a[14:7];
  endfunction
  function automatic logic [7:0] boot_model(input logic [7:0] i);
    logic [7:0] t;
    t = i * 8'd7;
    return t + 8'd3;
  endfunction

  assign rom_data = rom_model(rom_addr);

  membus_decode u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_rdata(bus_rdata), .bus_done(bus_done), .bus_err(bus_err),
    .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_data(rom_data)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access; results sampled on the falling edge where they are due
  task automatic access(input logic wr, input logic word, input logic [15:0] a,
                        input logic [15:0] d, output logic [15:0] q,
                        output logic e, output logic dn, output logic mid,
                        output logic rrd);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd = !wr; bus_wr = wr; bus_word = word;
    #1 rrd = rom_rd;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; bus_word = 1'b0;
    mid = bus_done;
    if (word) @(negedge clk);
    q = bus_rdata; e = bus_err; dn = bus_done;
  endtask

  // Vector table: wr, word, addr, wdata, expected rdata, expected err, req
  localparam int NV = 21;
  localparam logic        T_WR   [NV] = '{1,0,1,0,1,0,1,0,1,0,1,0,0,1,0,0,1,0,0,0,0};
  localparam logic        T_WORD [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,1,0,0,1,1};
  localparam logic [15:0] T_ADDR [NV] = '{
    16'h8000, 16'h8000, 16'h9FFF, 16'h9FFF,   // R5
    16'hC123, 16'hE123, 16'hFDFF, 16'hDDFF,   // R6
    16'hFF80, 16'hFF80, 16'hFFFE, 16'hFFFE,   // R7
    16'hA000, 16'hFE00, 16'hFFFF, 16'hFF7F,   // R8
    16'hC200, 16'hC200, 16'hC201, 16'hC200,   // R10
    16'hFFFE};                                // R11
  localparam logic [15:0] T_D [NV] = '{
    16'h0011, 0, 16'h00A7, 0, 16'h005C, 0, 16'h0033, 0,
    16'h0042, 0, 16'h0099, 0, 0, 16'h0077, 0, 0, 16'h1234, 0, 0, 0, 0};
  localparam logic [15:0] T_EXP [NV] = '{
    0, 16'h0011, 0, 16'h00A7, 0, 16'h005C, 0, 16'h0033,
    0, 16'h0042, 0, 16'h0099, 16'h00FF, 0, 16'h00FF, 16'h00FF,
    0, 16'h0034, 16'h0012, 16'h1234, 16'hFF99};
  localparam logic T_ERR [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,1,1,1,1,0,0,0,0,1};
  localparam int   T_REQ [NV] = '{5,5,5,5,6,6,6,6,7,7,7,7,8,8,8,8,10,10,10,10,11};

  logic [15:0] q;
  logic e, dn, mid, rrd;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_rd = 0; bus_wr = 0; bus_word = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 done after reset", bus_done, 0);
    chk("R1 err after reset", bus_err, 0);
    access(0, 0, 16'hFF50, 0, q, e, dn, mid, rrd);
    chk("R1 overlay on after reset", q, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      access(T_WR[i], T_WORD[i], T_ADDR[i], T_D[i], q, e, dn, mid, rrd);
      chk($sformatf("R%0d vector %0d done", T_REQ[i], i), dn, 1);
      chk($sformatf("R%0d vector %0d err", T_REQ[i], i), e, T_ERR[i]);
      if (T_WORD[i]) chk($sformatf("R10 vector %0d done low mid-word", i), mid, 0);
      if (!T_WR[i]) chk($sformatf("R%0d vector %0d data", T_REQ[i], i), q, T_EXP[i]);
    end

    // R12: byte read data and done one cycle after the strobe
    access(0, 0, 16'h8000, 0, q, e, dn, mid, rrd);
    chk("R12 byte done next cycle", dn, 1);
    chk("R12 byte data next cycle", q, 16'h0011);

    // R2: ROM reads
    access(0, 0, 16'h0150, 0, q, e, dn, mid, rrd);
    chk("R2 rom strobe", rrd, 1);
    chk("R2 rom data 0x0150", q, {8'h00, rom_model(15'h0150)});
    access(0, 0, 16'h7FFF, 0, q, e, dn, mid, rrd);
    chk("R2 rom data 0x7FFF", q, {8'h00, rom_model(15'h7FFF)});
    access(0, 0, 16'h0100, 0, q, e, dn, mid, rrd);
    chk("R3 boundary 0x0100 is ROM", q, {8'h00, rom_model(15'h0100)});

    // R3: boot overlay
    access(0, 0, 16'h0000, 0, q, e, dn, mid, rrd);
    chk("R3 boot byte 0", q, {8'h00, boot_model(8'h00)});
    chk("R3 no rom strobe", rrd, 0);
    access(0, 0, 16'h00FF, 0, q, e, dn, mid, rrd);
    chk("R3 boot byte 0xFF", q, {8'h00, boot_model(8'hFF)});

    // R9: writes to ROM and boot space ignored
    access(1, 0, 16'h0200, 16'h00AA, q, e, dn, mid, rrd);
    chk("R9 rom write no err", e, 0);
    chk("R9 rom write no strobe", rrd, 0);
    access(1, 0, 16'h0010, 16'h00AA, q, e, dn, mid, rrd);
    access(0, 0, 16'h0010, 0, q, e, dn, mid, rrd);
    chk("R9 boot byte unchanged", q, {8'h00, boot_model(8'h10)});

    // R4: control bit
    access(1, 0, 16'hFF50, 16'h0000, q, e, dn, mid, rrd);
    access(0, 0, 16'hFF50, 0, q, e, dn, mid, rrd);
    chk("R4 zero write keeps overlay", q, 16'h0001);
    access(1, 0, 16'hFF50, 16'h0001, q, e, dn, mid, rrd);
    chk("R4 control write no err", e, 0);
    access(0, 0, 16'hFF50, 0, q, e, dn, mid, rrd);
    chk("R4 overlay off", q, 16'h0000);
    access(0, 0, 16'h0010, 0, q, e, dn, mid, rrd);
    chk("R4 low range now ROM", q, {8'h00, rom_model(15'h0010)});
    access(1, 0, 16'hFF50, 16'h0000, q, e, dn, mid, rrd);
    access(0, 0, 16'hFF50, 0, q, e, dn, mid, rrd);
    chk("R4 overlay stays off", q, 16'h0000);

    // R1: reset restores overlay
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    access(0, 0, 16'h0010, 0, q, e, dn, mid, rrd);
    chk("R1 overlay back after reset", q, {8'h00, boot_model(8'h10)});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule